// File: doc/BRIEF.md
# CSR request routing decoder

This block sits in a processor agent and looks at every control/status register request that the agent's processor issues. From fields of the 40-bit physical address it decides whether the request stays inside the processor, is serviced by the agent itself, or must travel over the crossbar to another controller. Crossbar traffic goes either straight to the memory controller that the address names, or first to an intermediate memory controller that the agent is configured to use when the final target is another agent, an I/O controller or a processor.

For crossbar traffic the block checks the online vector that covers the destination. If the destination is not online, the request is turned into a high-priority machine check trap and is not forwarded. For processor-specific register pages the block also overwrites one page bit with the identity of the requesting processor, so that each processor reaches its own copy of the page.

Requests enter on a valid/ready handshake. The decision is registered and then held until the downstream side acknowledges it.

Top module: `csr_route_decoder`

## Requirements
- R1: After synchronous reset, `out_valid` is 0.
- R2: `in_ready` equals `!out_valid || out_ack`. A request accepted on `in_valid && in_ready` appears on the outputs with `out_valid`=1 in the next cycle. While `out_valid`=1 and `out_ack`=0, every output stays unchanged.
- R3: When address bits 39:32 are not all ones, the request is not CSR space. The decision is IGNORE (code 0), `out_trap`=0, `out_port`=0 and the address is unchanged.
- R4: A CSR request with class field (bits 31:30) equal to 0 is processor-local. It gets decision IGNORE (code 0) and `out_trap`=0 whatever the online vectors hold, and its address is passed through unchanged.
- R5: A CSR request with class field 1 is agent-local. It gets decision AGENT (code 1), `out_port`=0 and `out_trap`=0, and is never given decision XBAR.
- R6: A CSR request with class field 2 targets a memory controller. If `cfg_mc_online[xsel]`=1, where xsel is bits 29:27, the decision is XBAR (code 2) with `out_port`=xsel.
- R7: A class-2 request whose `cfg_mc_online[xsel]`=0 gets decision TRAP (code 3) with `out_trap`=1 and `out_port`=0.
- R8: A CSR request with class field 3 targets another agent, I/O controller or processor. If `cfg_agent_online[xsel]`=1, the decision is XBAR (code 2) with `out_port`=`cfg_inter_mc`.
- R9: A class-3 request whose `cfg_agent_online[xsel]`=0 gets decision TRAP (code 3) with `out_trap`=1 and `out_port`=0.
- R10: For CSR requests of class 1, 2 or 3 whose chip field (bits 26:24) has bit 2 set, address bit 19 (bit 3 of the page field, bits 23:16) is replaced by `in_req_id`. In every other case, and for all other address bits, the address is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can accept a request |
| in_addr | input | 40 | Physical address of the request |
| in_req_id | input | 1 | Which processor on the agent issued the request |
| cfg_mc_online | input | 8 | Online bit per memory controller |
| cfg_agent_online | input | 8 | Online bit per agent |
| cfg_inter_mc | input | 3 | Intermediate memory controller for agent-bound traffic |
| out_valid | output | 1 | Routing decision valid |
| out_ack | input | 1 | Downstream acknowledges the decision |
| out_decision | output | 2 | 0 IGNORE, 1 AGENT, 2 XBAR, 3 TRAP |
| out_port | output | 3 | Crossbar memory-controller port for XBAR |
| out_addr | output | 40 | Address after page rewrite |
| out_trap | output | 1 | High-priority machine check trap |

## Verification
The bench sends processor-local requests with every online bit cleared. A design that checked online bits for this class would raise a trap. For each of the two crossbar classes it flips the one online bit that matters, so a design that reads the memory-controller vector where it should read the agent vector, or routes to xsel instead of the intermediate controller, gives the wrong port or a spurious trap. It also sets and clears page bit 19 against both requester identities, with the chip processor bit on and off and on processor-local and non-CSR addresses. A wrong rewrite shows up as a flipped or stuck address bit. Acknowledge is withheld on some cycles, so a design that drops or changes a held decision loses or corrupts scoreboard items.

// File: rtl/csr_route_pkg.sv
package csr_route_pkg;

    localparam int ADDR_W         = 40;
    localparam int SPACE_HI       = 39;
    localparam int SPACE_LO       = 32;
    localparam int CLASS_HI       = 31;
    localparam int CLASS_LO       = 30;
    localparam int XSEL_HI        = 29;
    localparam int XSEL_LO        = 27;
    localparam int CHIP_HI        = 26;
    localparam int CHIP_LO        = 24;
    localparam int PAGE_HI        = 23;
    localparam int PAGE_LO        = 16;
    localparam int CHIP_PROC_BIT  = 2;
    localparam int PAGE_FORCE_BIT = 3;

    localparam int SPACE_W  = SPACE_HI - SPACE_LO + 1;
    localparam int XSEL_W   = XSEL_HI - XSEL_LO + 1;
    localparam int CHIP_W   = CHIP_HI - CHIP_LO + 1;
    localparam int PAGE_W   = PAGE_HI - PAGE_LO + 1;
    localparam int NUM_DEST = 1 << XSEL_W;
    localparam int FORCE_POS = PAGE_LO + PAGE_FORCE_BIT;

    typedef enum logic [1:0] {
        CL_PROC     = 2'd0,
        CL_AGENT    = 2'd1,
        CL_SYS_MC   = 2'd2,
        CL_SYS_NODE = 2'd3
    } class_e;

    typedef enum logic [1:0] {
        DEC_IGNORE = 2'd0,
        DEC_AGENT  = 2'd1,
        DEC_XBAR   = 2'd2,
        DEC_TRAP   = 2'd3
    } decision_e;

    typedef struct packed {
        decision_e          dec;
        logic [XSEL_W-1:0]  port;
        logic [ADDR_W-1:0]  addr;
        logic               trap;
    } route_t;

    function automatic logic addr_is_csr(input logic [ADDR_W-1:0] a);
        return &a[SPACE_HI:SPACE_LO];
    endfunction

    function automatic class_e addr_class(input logic [ADDR_W-1:0] a);
        return class_e'(a[CLASS_HI:CLASS_LO]);
    endfunction

    function automatic logic [XSEL_W-1:0] addr_xsel(input logic [ADDR_W-1:0] a);
        return a[XSEL_HI:XSEL_LO];
    endfunction

    function automatic logic addr_proc_page(input logic [ADDR_W-1:0] a);
        logic [CHIP_W-1:0] chip;
        chip = a[CHIP_HI:CHIP_LO];
        return chip[CHIP_PROC_BIT];
    endfunction

endpackage

// File: rtl/csr_route_classify.sv
module csr_route_classify
    import csr_route_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              req_id_i,
    output logic              csr_o,
    output class_e            cls_o,
    output logic [XSEL_W-1:0] xsel_o,
    output logic [ADDR_W-1:0] addr_o
);

    logic rewrite;

    always_comb begin
        csr_o   = addr_is_csr(addr_i);
        cls_o   = addr_class(addr_i);
        xsel_o  = addr_xsel(addr_i);
        rewrite = csr_o && (cls_o != CL_PROC) && addr_proc_page(addr_i);
        addr_o  = addr_i;
        if (rewrite) begin
            addr_o[FORCE_POS] = req_id_i;
        end
    end

endmodule

// File: rtl/csr_route_online_chk.sv
module csr_route_online_chk
    import csr_route_pkg::*;
(
    input  logic                csr_i,
    input  class_e              cls_i,
    input  logic [XSEL_W-1:0]   xsel_i,
    input  logic [NUM_DEST-1:0] mc_online_i,
    input  logic [NUM_DEST-1:0] agent_online_i,
    input  logic [XSEL_W-1:0]   inter_mc_i,
    output decision_e           dec_o,
    output logic [XSEL_W-1:0]   port_o
);

    logic mc_up;
    logic agent_up;

    always_comb begin
        mc_up    = mc_online_i[xsel_i];
        agent_up = agent_online_i[xsel_i];
        dec_o    = DEC_IGNORE;
        port_o   = '0;
        if (csr_i) begin
            unique case (cls_i)
                CL_PROC:  dec_o = DEC_IGNORE;
                CL_AGENT: dec_o = DEC_AGENT;
                CL_SYS_MC: begin
                    if (mc_up) begin
                        dec_o  = DEC_XBAR;
                        port_o = xsel_i;
                    end else begin
                        dec_o  = DEC_TRAP;
                    end
                end
                CL_SYS_NODE: begin
                    if (agent_up) begin
                        dec_o  = DEC_XBAR;
                        port_o = inter_mc_i;
                    end else begin
                        dec_o  = DEC_TRAP;
                    end
                end
                default: dec_o = DEC_IGNORE;
            endcase
        end
    end

endmodule

// File: rtl/csr_route_hold.sv
module csr_route_hold
    import csr_route_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    output logic   in_ready,
    input  route_t nxt_i,
    input  logic   out_ack,
    output logic   out_valid,
    output route_t held_o
);

    logic   vld_q;
    route_t data_q;

    assign in_ready  = !vld_q || out_ack;
    assign out_valid = vld_q;
    assign held_o    = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            data_q <= '0;
        end else if (in_valid && in_ready) begin
            vld_q  <= 1'b1;
            data_q <= nxt_i;
        end else if (out_ack) begin
            vld_q  <= 1'b0;
        end
    end

    // R2: a decision waiting for acknowledge is neither dropped nor altered
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ack) |=> (out_valid && $stable(held_o)));

    // R2: a request accepted shows up valid one cycle later
    a_r2_accept_valid: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/csr_route_decoder.sv
module csr_route_decoder
    import csr_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic                in_req_id,
    input  logic [NUM_DEST-1:0] cfg_mc_online,
    input  logic [NUM_DEST-1:0] cfg_agent_online,
    input  logic [XSEL_W-1:0]   cfg_inter_mc,
    output logic                out_valid,
    input  logic                out_ack,
    output logic [1:0]          out_decision,
    output logic [XSEL_W-1:0]   out_port,
    output logic [ADDR_W-1:0]   out_addr,
    output logic                out_trap
);

    logic              csr;
    class_e            cls;
    logic [XSEL_W-1:0] xsel;
    logic [ADDR_W-1:0] new_addr;
    decision_e         dec;
    logic [XSEL_W-1:0] port;
    route_t            nxt;
    route_t            held;

    csr_route_classify u_classify (
        .addr_i   (in_addr),
        .req_id_i (in_req_id),
        .csr_o    (csr),
        .cls_o    (cls),
        .xsel_o   (xsel),
        .addr_o   (new_addr)
    );

    csr_route_online_chk u_online (
        .csr_i          (csr),
        .cls_i          (cls),
        .xsel_i         (xsel),
        .mc_online_i    (cfg_mc_online),
        .agent_online_i (cfg_agent_online),
        .inter_mc_i     (cfg_inter_mc),
        .dec_o          (dec),
        .port_o         (port)
    );

    always_comb begin
        nxt.dec  = dec;
        nxt.port = port;
        nxt.addr = new_addr;
        nxt.trap = (dec == DEC_TRAP);
    end

    csr_route_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .nxt_i     (nxt),
        .out_ack   (out_ack),
        .out_valid (out_valid),
        .held_o    (held)
    );

    assign out_decision = held.dec;
    assign out_port     = held.port;
    assign out_addr     = held.addr;
    assign out_trap     = held.trap;

    // R3: addresses outside CSR space are never forwarded nor trapped
    a_r3_noncsr_ignored: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !(&in_addr[SPACE_HI:SPACE_LO]))
        |=> (out_decision == 2'd0 && !out_trap));

    // R4: processor-local requests pass untouched and never trap
    a_r4_local_untouched: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (&in_addr[SPACE_HI:SPACE_LO])
         && in_addr[CLASS_HI:CLASS_LO] == 2'd0)
        |=> (out_addr == $past(in_addr) && !out_trap && out_decision == 2'd0));

    // R5: agent-local requests never go to the crossbar
    a_r5_agent_stays: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (&in_addr[SPACE_HI:SPACE_LO])
         && in_addr[CLASS_HI:CLASS_LO] == 2'd1)
        |=> (out_decision == 2'd1 && !out_trap));

    // R10: only the forced page bit may differ from the request address
    a_r10_other_bits_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready)
        |=> (out_addr[ADDR_W-1:FORCE_POS+1] == $past(in_addr[ADDR_W-1:FORCE_POS+1])
             && out_addr[FORCE_POS-1:0] == $past(in_addr[FORCE_POS-1:0])));

    // R7, R9: a trap is never paired with a crossbar port
    a_r7_trap_no_port: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_trap) |-> (out_port == '0 && out_decision == 2'd3));

endmodule

// File: tb/test_csr_route_decoder.sv
module test_csr_route_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [39:0] in_addr = '0;
    logic        in_req_id = 1'b0;
    logic [7:0]  cfg_mc_online = '0;
    logic [7:0]  cfg_agent_online = '0;
    logic [2:0]  cfg_inter_mc = '0;
    logic        out_valid;
    logic        out_ack = 1'b0;
    logic [1:0]  out_decision;
    logic [2:0]  out_port;
    logic [39:0] out_addr;
    logic        out_trap;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [1:0]  dec;
        logic [2:0]  port;
        logic [39:0] addr;
        logic        trap;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    csr_route_decoder i_csr_route_decoder (
        .clk              (clk),
        .rst              (rst),
        .in_valid         (in_valid),
        .in_ready         (in_ready),
        .in_addr          (in_addr),
        .in_req_id        (in_req_id),
        .cfg_mc_online    (cfg_mc_online),
        .cfg_agent_online (cfg_agent_online),
        .cfg_inter_mc     (cfg_inter_mc),
        .out_valid        (out_valid),
        .out_ack          (out_ack),
        .out_decision     (out_decision),
        .out_port         (out_port),
        .out_addr         (out_addr),
        .out_trap         (out_trap)
    );

    function automatic logic [39:0] mk(input logic csr, input logic [1:0] cls,
                                       input logic [2:0] xs, input logic [2:0] chip,
                                       input logic [7:0] page);
        logic [39:0] a;
        a = 40'h00_0000_A5C3;
        a[39:32] = csr ? 8'hFF : 8'h7F;
        a[31:30] = cls;
        a[29:27] = xs;
        a[26:24] = chip;
        a[23:16] = page;
        return a;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: computes the expected result from the requirements and sends
    task automatic send(input logic [39:0] a, input logic id, input logic [7:0] mco,
                        input logic [7:0] ago, input logic [2:0] imc, input string req);
        exp_t e;
        e.dec = 2'd0; e.port = 3'd0; e.addr = a; e.trap = 1'b0; e.req = req;
        if (a[39:32] == 8'hFF) begin
            case (a[31:30])
                2'd0: e.dec = 2'd0;                                   // R4
                2'd1: e.dec = 2'd1;                                   // R5
                2'd2: if (mco[a[29:27]]) begin e.dec = 2'd2; e.port = a[29:27]; end
                      else begin e.dec = 2'd3; e.trap = 1'b1; end      // R6 R7
                2'd3: if (ago[a[29:27]]) begin e.dec = 2'd2; e.port = imc; end
                      else begin e.dec = 2'd3; e.trap = 1'b1; end      // R8 R9
            endcase
            if (a[31:30] != 2'd0 && a[26]) e.addr[19] = id;            // R10
        end
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_req_id = id;
        cfg_mc_online = mco; cfg_agent_online = ago; cfg_inter_mc = imc;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        sb.push_back(e);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    // acknowledge pattern: withheld one cycle in three
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2 out_ack = (cyc % 3) != 0;
    end

    // monitor
    logic        stall_seen = 1'b0;
    logic [39:0] stall_addr;
    logic [1:0]  stall_dec;
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_seen) begin
                check(out_valid && out_addr == stall_addr && out_decision == stall_dec,
                      "R2", "held output changed", {24'd0, out_addr}, {24'd0, stall_addr});
            end
            stall_seen = 1'b0;
            if (out_valid && !out_ack) begin
                stall_seen = 1'b1;
                stall_addr = out_addr;
                stall_dec  = out_decision;
            end
            if (out_valid && out_ack) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2", "unexpected output", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_decision == e.dec, e.req, "decision", 64'(out_decision), 64'(e.dec));
                    check(out_port == e.port, e.req, "port", 64'(out_port), 64'(e.port));
                    check(out_addr == e.addr, e.req, "addr", 64'(out_addr), 64'(e.addr));
                    check(out_trap == e.trap, e.req, "trap", 64'(out_trap), 64'(e.trap));
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        check(in_ready == 1'b1, "R2", "ready when empty", 64'(in_ready), 64'd1);

        // R3 non-CSR, even with processor bit and class 2
        send(mk(1'b0, 2'd2, 3'd1, 3'b100, 8'h08), 1'b0, 8'h00, 8'h00, 3'd5, "R3");
        send(mk(1'b0, 2'd3, 3'd4, 3'b111, 8'h00), 1'b1, 8'hFF, 8'hFF, 3'd2, "R3");
        // R4 processor-local, all offline, processor page bit set: no rewrite
        send(mk(1'b1, 2'd0, 3'd6, 3'b100, 8'h00), 1'b1, 8'h00, 8'h00, 3'd1, "R4");
        send(mk(1'b1, 2'd0, 3'd2, 3'b000, 8'hFF), 1'b0, 8'h00, 8'h00, 3'd0, "R4");
        // R5 agent-local, with R10 rewrite both ways
        send(mk(1'b1, 2'd1, 3'd7, 3'b100, 8'h00), 1'b1, 8'h00, 8'h00, 3'd3, "R5 R10");
        send(mk(1'b1, 2'd1, 3'd0, 3'b101, 8'hFF), 1'b0, 8'h00, 8'h00, 3'd3, "R5 R10");
        send(mk(1'b1, 2'd1, 3'd0, 3'b011, 8'h00), 1'b1, 8'h00, 8'h00, 3'd3, "R5 R10");
        // R6/R7 each memory controller online then offline
        for (int i = 0; i < 8; i++) begin
            send(mk(1'b1, 2'd2, 3'(i), 3'b000, 8'h5A), 1'b0, 8'(1 << i), 8'h00, 3'd0, "R6");
            send(mk(1'b1, 2'd2, 3'(i), 3'b000, 8'h5A), 1'b0, ~8'(1 << i), 8'hFF, 3'd0, "R7");
        end
        // R8/R9 agent-bound via intermediate controller
        for (int i = 0; i < 8; i++) begin
            send(mk(1'b1, 2'd3, 3'(i), 3'b110, 8'h00), 1'(i), 8'h00, 8'(1 << i), 3'(7 - i), "R8 R10");
            send(mk(1'b1, 2'd3, 3'(i), 3'b010, 8'h08), 1'b0, 8'hFF, ~8'(1 << i), 3'(i), "R9 R10");
        end
        // R10 rewrite on memory-controller class with requester 0 clearing bit 19
        send(mk(1'b1, 2'd2, 3'd3, 3'b100, 8'hFF), 1'b0, 8'hFF, 8'h00, 3'd0, "R10");
        send(mk(1'b1, 2'd2, 3'd3, 3'b100, 8'h00), 1'b1, 8'h00, 8'h00, 3'd0, "R10 R7");

        repeat (20) @(negedge clk);
        check(sb.size() == 0, "R2", "items left in scoreboard", 64'(sb.size()), 64'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "R2", "watchdog expired", 64'd0, 64'd1);
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule